// File: doc/BRIEF.md
# Line Clamp and Blanking Pulse Generator

This block produces three per-line timing pulses for an image-sensor readout path: a black-level clamp pulse, a pre-blank pulse that masks the digital output, and a horizontal blanking pulse. A 12-bit pixel position counter restarts on every line-start strobe. Each pulse is built by flipping a level at programmed pixel positions. The clamp and pre-blank pulses are active low and each start the line at a programmable level. The blanking pulse is active high, starts every line inactive, and has six flip points. An alternation mode picks which subset of those six flip points is used, based on whether the line is odd or even.

Ten independent configuration sets are held in a small register array, one set for each vertical sequence. A sequence index input picks the set. That index is sampled only on the line-start strobe, and the chosen set is copied into an active register. Neither a later change of the index nor a configuration write can therefore alter a line already in progress. A field-start input, given together with the line-start strobe, marks the first line of a field and makes it odd.

Top module: `lcb_line_pulses`

## Requirements
- R1: On the cycle after a clock edge where `line_start` is high, `pixel_pos` is 0. After that it increases by one on each clock cycle.
- R2: `pixel_pos` saturates at 4095 and holds there until the next `line_start`. A flip position of 4095 never takes effect, and no output changes while the counter is saturated.
- R3: While `pixel_pos` equals p, `clamp_n` equals the clamp start level XOR the parity of the number of clamp flip positions less than or equal to p. Two equal flip positions cancel each other.
- R4: `preblank_n` follows the same rule as R3, using its own start level and its own two flip positions.
- R5: `hblank` is 0 at the start of each line and, while `pixel_pos` equals p, equals the parity of the number of enabled blanking flip positions less than or equal to p.
- R6: The alternation mode is a 2-bit field. Mode 0 enables all six blanking flip positions. Mode 1 enables flips 1 and 2 on odd lines and flips 3 to 6 on even lines. Modes 2 and 3 enable flips 1 and 2 on even lines and flips 3 to 6 on odd lines.
- R7: A `line_start` with `field_start` high makes `line_odd` 1. A `line_start` without it inverts `line_odd`. `line_odd` changes at no other time.
- R8: A write with `cfg_we` high stores `cfg_wdata` in word `cfg_idx` of set `cfg_seq`. Words 0 and 1 are the clamp flips, words 2 and 3 the pre-blank flips, and words 4 to 9 blanking flips 1 to 6. Word 10 is control: bit 0 is the clamp start level, bit 1 the pre-blank start level, and bits 3:2 the alternation mode.
- R9: The set is chosen by `seq_sel` only when `line_start` is high. Changes to `seq_sel` and configuration writes during a line have no effect until the next line.
- R10: A `line_start` with `seq_sel` of 10 or more keeps the previous active set. Writes with `cfg_seq` of 10 or more, or with `cfg_idx` of 11 or more, change nothing.
- R11: After reset, `clamp_n` and `preblank_n` are 1, `hblank` is 0, `pixel_pos` is 4095 and `line_odd` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_seq | input | 4 | Sequence set addressed by the write |
| cfg_idx | input | 4 | Word within the set addressed by the write |
| cfg_wdata | input | 12 | Data to write |
| seq_sel | input | 4 | Sequence index, sampled on line start |
| line_start | input | 1 | One-cycle line start strobe |
| field_start | input | 1 | Marks the line as first of a field (with line_start) |
| clamp_n | output | 1 | Black-level clamp pulse, active low |
| preblank_n | output | 1 | Pre-blank pulse, active low |
| hblank | output | 1 | Horizontal blanking pulse, active high |
| line_odd | output | 1 | 1 on odd lines |
| pixel_pos | output | 12 | Current pixel position within the line |

## Verification
The bench goes after a flip at pixel 0, which must already show on the first pixel of the line. A design that compares against the registered count instead of the next count would show it one pixel late. Two equal clamp flips must cancel, which catches a design that ORs the matches instead of XOR-ing them. Every alternation mode is run on both line parities, so a swapped subset or a parity that is never re-forced by field start shows up as a wrong blanking waveform. An overlong line checks saturation and the disabled value 4095: a wrapping counter would fire the early flips a second time. Mid-line index changes and writes, out-of-range indexes and stray word addresses expose a design that reads the array live, or that flattens the set and word into one address so that a stray word lands in the next set.

// File: rtl/lcb_pkg.sv
package lcb_pkg;
  localparam int PIX_W     = 12;
  localparam int PAIR_TOGS = 2;
  localparam int HBK_TOGS  = 6;
  localparam int SET_WORDS = 2 * PAIR_TOGS + HBK_TOGS + 1;
  localparam int IDX_W     = $clog2(SET_WORDS);

  localparam int W_CLP  = 0;
  localparam int W_PBK  = W_CLP + PAIR_TOGS;
  localparam int W_HBK  = W_PBK + PAIR_TOGS;
  localparam int W_CTRL = W_HBK + HBK_TOGS;

  typedef logic [PIX_W-1:0] pix_t;

  typedef struct packed {
    logic [1:0]                alt_mode;
    logic                      pbk_start;
    logic                      clp_start;
    pix_t [PAIR_TOGS-1:0]      clp_tog;
    pix_t [PAIR_TOGS-1:0]      pbk_tog;
    pix_t [HBK_TOGS-1:0]       hbk_tog;
  } seq_cfg_t;
endpackage

// File: rtl/lcb_line_timer.sv
module lcb_line_timer
  import lcb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic line_start,
  input  logic field_start,
  output pix_t pos,
  output pix_t nxt_pos,
  output logic adv,
  output logic line_odd,
  output logic nxt_odd
);
  localparam pix_t POS_MAX = '1;

  always_comb begin
    if (line_start)          nxt_pos = '0;
    else if (pos == POS_MAX) nxt_pos = pos;
    else                     nxt_pos = pos + pix_t'(1);
    adv     = line_start || (pos != POS_MAX);
    nxt_odd = field_start | ~line_odd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos      <= POS_MAX;
      line_odd <= 1'b0;
    end else begin
      pos <= nxt_pos;
      if (line_start) line_odd <= nxt_odd;
    end
  end

  // R1
  start_zero_chk: assert property (@(posedge clk) disable iff (rst)
    line_start |=> pos == '0);
  // R1
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (!line_start && pos != POS_MAX) |=> pos == $past(pos) + pix_t'(1));
  // R2
  sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!line_start && pos == POS_MAX) |=> pos == POS_MAX);
  // R7
  field_odd_chk: assert property (@(posedge clk) disable iff (rst)
    (line_start && field_start) |=> line_odd);
  // R7
  parity_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (line_start && !field_start) |=> line_odd != $past(line_odd));
  // R7
  parity_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !line_start |=> $stable(line_odd));
endmodule

// File: rtl/lcb_toggle_pulse.sv
module lcb_toggle_pulse
  import lcb_pkg::*;
#(
  parameter int   NTOG    = 2,
  parameter logic RST_LVL = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic                  adv,
  input  logic                  start_lvl,
  input  pix_t                  nxt_pos,
  input  pix_t [NTOG-1:0]       togs,
  input  logic [NTOG-1:0]       tog_en,
  output logic                  lvl
);
  localparam pix_t OFF_POS = '1;

  logic hit;
  logic lvl_d;

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < NTOG; i++) begin
      if (adv && tog_en[i] && togs[i] != OFF_POS && togs[i] == nxt_pos)
        hit = ~hit;
    end
    lvl_d = (load ? start_lvl : lvl) ^ hit;
  end

  always_ff @(posedge clk) begin
    if (rst) lvl <= RST_LVL;
    else     lvl <= lvl_d;
  end

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!adv && !load) |=> $stable(lvl));
endmodule

// File: rtl/lcb_cfg_store.sv
module lcb_cfg_store
  import lcb_pkg::*;
#(
  parameter int NUM_SEQ = 10,
  parameter int SEL_W   = $clog2(NUM_SEQ)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_seq,
  input  logic [IDX_W-1:0] wr_idx,
  input  pix_t             wr_data,
  input  logic [SEL_W-1:0] rd_seq,
  output seq_cfg_t         rd_cfg,
  output logic             rd_ok
);
  pix_t mem [NUM_SEQ][SET_WORDS];

  logic             wr_ok;
  logic [SEL_W-1:0] rd_row;
  pix_t             ctrl_w;

  assign wr_ok  = wr_en && (int'(wr_seq) < NUM_SEQ) && (int'(wr_idx) < SET_WORDS);
  assign rd_ok  = int'(rd_seq) < NUM_SEQ;
  assign rd_row = rd_ok ? rd_seq : '0;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_seq][wr_idx] <= wr_data;
  end

  assign ctrl_w = mem[rd_row][W_CTRL];

  always_comb begin
    rd_cfg.clp_start = ctrl_w[0];
    rd_cfg.pbk_start = ctrl_w[1];
    rd_cfg.alt_mode  = ctrl_w[3:2];
    for (int i = 0; i < PAIR_TOGS; i++) begin
      rd_cfg.clp_tog[i] = mem[rd_row][W_CLP + i];
      rd_cfg.pbk_tog[i] = mem[rd_row][W_PBK + i];
    end
    for (int i = 0; i < HBK_TOGS; i++)
      rd_cfg.hbk_tog[i] = mem[rd_row][W_HBK + i];
  end
endmodule

// File: rtl/lcb_line_pulses.sv
module lcb_line_pulses
  import lcb_pkg::*;
#(
  parameter int NUM_SEQ = 10,
  localparam int SEL_W  = $clog2(NUM_SEQ)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_seq,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [PIX_W-1:0] cfg_wdata,
  input  logic [SEL_W-1:0] seq_sel,
  input  logic             line_start,
  input  logic             field_start,
  output logic             clamp_n,
  output logic             preblank_n,
  output logic             hblank,
  output logic             line_odd,
  output logic [PIX_W-1:0] pixel_pos
);
  localparam int   PAIR_FIRST = 2;
  localparam pix_t POS_MAX    = '1;

  seq_cfg_t            rd_cfg, act_cfg, use_cfg;
  logic                rd_ok, take_new;
  logic [HBK_TOGS-1:0] act_mask, use_mask;
  pix_t                nxt_pos;
  logic                adv, nxt_odd;

  function automatic logic [HBK_TOGS-1:0] alt_mask(input logic [1:0] mode,
                                                   input logic odd);
    logic [HBK_TOGS-1:0] first_pair;
    first_pair = '0;
    first_pair[PAIR_FIRST-1:0] = '1;
    if (mode == 2'd0)      return '1;
    else if (mode == 2'd1) return odd ? first_pair : ~first_pair;
    else                   return odd ? ~first_pair : first_pair;
  endfunction

  lcb_cfg_store #(.NUM_SEQ(NUM_SEQ), .SEL_W(SEL_W)) store_i (
    .clk     (clk),
    .wr_en   (cfg_we),
    .wr_seq  (cfg_seq),
    .wr_idx  (cfg_idx),
    .wr_data (cfg_wdata),
    .rd_seq  (seq_sel),
    .rd_cfg  (rd_cfg),
    .rd_ok   (rd_ok)
  );

  lcb_line_timer timer_i (
    .clk         (clk),
    .rst         (rst),
    .line_start  (line_start),
    .field_start (field_start),
    .pos         (pixel_pos),
    .nxt_pos     (nxt_pos),
    .adv         (adv),
    .line_odd    (line_odd),
    .nxt_odd     (nxt_odd)
  );

  assign take_new = line_start && rd_ok;
  assign use_cfg  = take_new ? rd_cfg : act_cfg;
  assign use_mask = line_start ? alt_mask(use_cfg.alt_mode, nxt_odd) : act_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_cfg.clp_start <= 1'b1;
      act_cfg.pbk_start <= 1'b1;
      act_cfg.alt_mode  <= 2'd0;
      act_cfg.clp_tog   <= '1;
      act_cfg.pbk_tog   <= '1;
      act_cfg.hbk_tog   <= '1;
      act_mask          <= '1;
    end else begin
      if (take_new)   act_cfg  <= rd_cfg;
      if (line_start) act_mask <= use_mask;
    end
  end

  lcb_toggle_pulse #(.NTOG(PAIR_TOGS), .RST_LVL(1'b1)) clamp_i (
    .clk       (clk),
    .rst       (rst),
    .load      (line_start),
    .adv       (adv),
    .start_lvl (use_cfg.clp_start),
    .nxt_pos   (nxt_pos),
    .togs      (use_cfg.clp_tog),
    .tog_en    ({PAIR_TOGS{1'b1}}),
    .lvl       (clamp_n)
  );

  lcb_toggle_pulse #(.NTOG(PAIR_TOGS), .RST_LVL(1'b1)) preblank_i (
    .clk       (clk),
    .rst       (rst),
    .load      (line_start),
    .adv       (adv),
    .start_lvl (use_cfg.pbk_start),
    .nxt_pos   (nxt_pos),
    .togs      (use_cfg.pbk_tog),
    .tog_en    ({PAIR_TOGS{1'b1}}),
    .lvl       (preblank_n)
  );

  lcb_toggle_pulse #(.NTOG(HBK_TOGS), .RST_LVL(1'b0)) hblank_i (
    .clk       (clk),
    .rst       (rst),
    .load      (line_start),
    .adv       (adv),
    .start_lvl (1'b0),
    .nxt_pos   (nxt_pos),
    .togs      (use_cfg.hbk_tog),
    .tog_en    (use_mask),
    .lvl       (hblank)
  );

  // R2
  sat_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (pixel_pos == POS_MAX && !line_start)
      |=> ($stable(clamp_n) && $stable(preblank_n) && $stable(hblank)));
  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !line_start |=> (act_cfg == $past(act_cfg) && $stable(act_mask)));
  // R6
  mask_shape_chk: assert property (@(posedge clk) disable iff (rst)
    line_start |=> ($countones(act_mask) == PAIR_FIRST
                    || $countones(act_mask) == HBK_TOGS - PAIR_FIRST
                    || act_mask == '1));
endmodule

// File: tb/lcb_line_pulses_tb.sv
module lcb_line_pulses_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_seq = '0;
  logic [3:0]  cfg_idx = '0;
  logic [11:0] cfg_wdata = '0;
  logic [3:0]  seq_sel = '0;
  logic        line_start = 1'b0;
  logic        field_start = 1'b0;
  logic        clamp_n, preblank_n, hblank, line_odd;
  logic [11:0] pixel_pos;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  int sh_tog [10][10];
  int sh_ctrl [10];
  int cur_tog [10];
  int cur_ctrl;
  int exp_odd;
  int cur_mask [6];

  always #5 clk = ~clk;

  lcb_line_pulses dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_seq(cfg_seq), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .seq_sel(seq_sel), .line_start(line_start),
    .field_start(field_start), .clamp_n(clamp_n), .preblank_n(preblank_n),
    .hblank(hblank), .line_odd(line_odd), .pixel_pos(pixel_pos)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles == 100000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R8 word layout: 0..1 clamp, 2..3 preblank, 4..9 blanking, 10 control
  task automatic write_cfg(input int s, input int idx, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_seq = 4'(s); cfg_idx = 4'(idx); cfg_wdata = 12'(d);
    // R10 stray set or word is ignored
    if (s < 10 && idx < 11) begin
      if (idx == 10) sh_ctrl[s] = d;
      else           sh_tog[s][idx] = d;
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic int gen_tog(input int s, input int w);
    int c0;
    c0 = (s * 3) % 20;
    case (w)
      0: return c0;
      1: return (s == 9) ? c0 : c0 + 5 + s;
      2: return s + 2;
      3: return (s == 4) ? 4095 : 30 - s;
      default: return ((s == 7 && w == 8) || (s == 2 && w == 9)) ? 4095
                      : 4 * (w - 4) + 1 + (s % 3);
    endcase
  endfunction

  function automatic int lvl_of(input int start, input int first, input int n,
                                input int p, input bit use_mask);
    int cnt = 0;
    int pe = (p > 4095) ? 4095 : p;
    for (int i = 0; i < n; i++) begin
      if (cur_tog[first + i] != 4095 && cur_tog[first + i] <= pe &&
          (!use_mask || cur_mask[i] != 0))
        cnt++;
    end
    return start ^ (cnt % 2);
  endfunction

  task automatic run_line(input int s, input int fs, input int len, input bit mid);
    int alt;
    @(negedge clk);
    seq_sel = 4'(s); line_start = 1'b1; field_start = fs[0];
    if (s < 10) begin
      for (int w = 0; w < 10; w++) cur_tog[w] = sh_tog[s][w];
      cur_ctrl = sh_ctrl[s];
    end
    exp_odd = fs ? 1 : (exp_odd ^ 1);
    alt = (cur_ctrl >> 2) & 3;
    for (int k = 0; k < 6; k++) begin
      if (alt == 0)      cur_mask[k] = 1;
      else if (alt == 1) cur_mask[k] = ((k < 2) == (exp_odd == 1)) ? 1 : 0;
      else               cur_mask[k] = ((k < 2) == (exp_odd == 0)) ? 1 : 0;
    end
    @(negedge clk);
    line_start = 1'b0; field_start = 1'b0;
    for (int p = 0; p < len; p++) begin
      if (p > 0) @(negedge clk);
      chk(int'(pixel_pos) == ((p > 4095) ? 4095 : p), "R1/R2 pixel_pos",
          int'(pixel_pos), (p > 4095) ? 4095 : p);
      chk(int'(line_odd) == exp_odd, "R7 line_odd", int'(line_odd), exp_odd);
      chk(int'(clamp_n) == lvl_of(cur_ctrl & 1, 0, 2, p, 1'b0), "R3 clamp_n",
          int'(clamp_n), lvl_of(cur_ctrl & 1, 0, 2, p, 1'b0));
      chk(int'(preblank_n) == lvl_of((cur_ctrl >> 1) & 1, 2, 2, p, 1'b0),
          "R4 preblank_n", int'(preblank_n), lvl_of((cur_ctrl >> 1) & 1, 2, 2, p, 1'b0));
      chk(int'(hblank) == lvl_of(0, 4, 6, p, 1'b1), "R5/R6 hblank",
          int'(hblank), lvl_of(0, 4, 6, p, 1'b1));
      // R9 mid-line stimulus: change index and rewrite the active set
      if (mid && p == 10) begin
        seq_sel = 4'((s + 1) % 10);
        cfg_we = 1'b1; cfg_seq = 4'(s); cfg_idx = 4'd0; cfg_wdata = 12'd4095;
        sh_tog[s][0] = 4095;
      end
      if (mid && p == 11) cfg_we = 1'b0;
    end
  endtask

  initial begin
    exp_odd = 0;
    cur_ctrl = 3;
    for (int w = 0; w < 10; w++) cur_tog[w] = 4095;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    chk(clamp_n == 1'b1, "R11 clamp_n", int'(clamp_n), 1);
    chk(preblank_n == 1'b1, "R11 preblank_n", int'(preblank_n), 1);
    chk(hblank == 1'b0, "R11 hblank", int'(hblank), 0);
    chk(pixel_pos == 12'hFFF, "R11 pixel_pos", int'(pixel_pos), 4095);
    chk(line_odd == 1'b0, "R11 line_odd", int'(line_odd), 0);

    for (int s = 0; s < 10; s++) begin
      for (int w = 0; w < 10; w++) write_cfg(s, w, gen_tog(s, w));
      write_cfg(s, 10, (s & 1) | (((s >> 1) & 1) << 1) | ((s % 4) << 2));
    end

    // R3 R4 R5 R6 sweep over all sets on both parities
    for (int s = 0; s < 10; s++) run_line(s, (s == 0) ? 1 : 0, 48, 1'b0);
    run_line(0, 1, 48, 1'b0);
    for (int s = 0; s < 10; s++) run_line(s, 0, 48, 1'b0);

    // R9 mid-line changes take effect only on the next line
    run_line(3, 0, 48, 1'b1);
    run_line(3, 0, 48, 1'b0);

    // R10 out-of-range index keeps the previous set
    run_line(11, 0, 48, 1'b0);

    // R10 stray writes are ignored
    write_cfg(0, 12, 7);
    write_cfg(0, 11, 9);
    write_cfg(12, 0, 5);
    run_line(1, 1, 48, 1'b0);
    run_line(0, 0, 48, 1'b0);

    // R2 overlong line: saturation and disabled flip value
    run_line(2, 0, 4200, 1'b0);
    run_line(5, 0, 48, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule